// File: doc/BRIEF.md
# Seconds Counter with Match Alarms

This block is a memory-mapped real-time seconds counter. A one-second tick advances a 32-bit up counter and, in the same cycle, steps a companion down counter the other way. Software keeps the down counter equal to the bitwise complement of the up counter. Two 32-bit compare registers watch the up counter. On equality they latch sticky status bits, which can raise an interrupt and can be routed to a wake (on-switch) output. A control register also carries a counter hold, a software counter reset and a wake force.

The counter, the control register and a key register sit in a retained domain. That domain is cleared only by the power-on reset `por_ni`. The system reset `rst_ni` clears the control register and the counter pair only when the key register does not hold the magic value. Software therefore writes the magic key once after first power-up, and later system resets leave the timebase running.

A 32-word scratch RAM sits in the upper half of the register window.

Top module: `sec_match_timer`

## Requirements
- R1: The register word offsets are: 0x00 up count, 0x04 down count, 0x08 compare 0, 0x0C compare 1, 0x10 control, 0x14 status, 0x18 key, and 0x80 to 0xFC scratch RAM. Reads from any other offset return 0, and writes to them change nothing. Control bit 5 always reads 0.
- R2: A cycle with `tick_i` high adds 1 to the up count and subtracts 1 from the down count on the next clock edge. While control bit 6 (hold) is set, the tick changes neither counter.
- R3: When the up count equals compare k (k = 0 or 1), status bit k is set on the next edge. The bit stays set until a write to the status register with bit k = 1. A status write with bit k = 0 leaves the bit unchanged.
- R4: `irq_o` is high while status bit k and control bit k (alarm enable k) are both set, for either k. A latched status bit with its enable cleared does not raise `irq_o`.
- R5: Control bits 2 and 3 route compare 0 and compare 1 to the wake path. A compare hit whose route is enabled sets status bit 2, which is cleared by writing 1 to it. `wake_o` is high while a routed status bit k is set.
- R6: While control bit 7 is set, `wake_o` is high regardless of status.
- R7: While control bit 4 (software reset) is set, the counters are held at up = 0 and down = 0xFFFFFFFF, and ticks are ignored. Counting resumes once the bit is cleared.
- R8: The 32 scratch RAM words are readable and writable, and they are not changed by the software reset.
- R9: On `rst_ni` low, if the key register does not hold 0xB5C13F27, the control register clears and the counters return to 0 and 0xFFFFFFFF. If the key matches, control and counter values are kept. The key register reads back the value last written.
- R10: After `por_ni`: control, status and key read 0; the up count reads 0; the down count reads 0xFFFFFFFF; both compare registers read 0xFFFFFFFF; `irq_o` and `wake_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Asynchronous power-on reset, active low, clears the retained domain |
| rst_ni | input | 1 | System reset, active low, conditional on the key |
| tick_i | input | 1 | One-cycle pulse per second |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 1 | Alarm interrupt |
| wake_o | output | 1 | On-switch wake output |

## Verification
The bench builds the block with its default AW = 8 and RAM_WORDS = 32. With these values the scratch RAM fills exactly the upper half of the address window, so both end words 0x80 and 0xFC can be reached. The offsets 0x1C and 0x20 fall in the unmapped gap below the RAM. The compare values are placed a few ticks ahead of the counter. This exercises latching, sticky hold and parking in tens of cycles. Two system reset pulses, one before and one after the key is written, cover both the clearing branch and the retaining branch.

// File: rtl/sec_match_pkg.sv
package sec_match_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned NUM_CMP = 2;

  localparam int unsigned OFS_UP   = 'h00;
  localparam int unsigned OFS_DN   = 'h04;
  localparam int unsigned OFS_CMP0 = 'h08;
  localparam int unsigned OFS_CTRL = 'h10;
  localparam int unsigned OFS_STS  = 'h14;
  localparam int unsigned OFS_KEY  = 'h18;
  localparam int unsigned OFS_RAM  = 'h80;

  localparam int unsigned CB_EN0   = 0;
  localparam int unsigned CB_WK0   = 2;
  localparam int unsigned CB_SRST  = 4;
  localparam int unsigned CB_HOLD  = 6;
  localparam int unsigned CB_FORCE = 7;
  localparam logic [7:0]  CTRL_MASK = 8'hDF;

  localparam int unsigned SB_WAKE = 2;
endpackage

// File: rtl/sec_counter_pair.sv
module sec_counter_pair #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          por_ni,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          hold_i,
  input  logic          srst_i,
  input  logic          wr_up_i,
  input  logic          wr_dn_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] up_o,
  output logic [DW-1:0] dn_o
);
  logic [DW-1:0] up_q, dn_q;
  logic          step;

  assign step = tick_i && !hold_i;

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      up_q <= '0;
      dn_q <= '1;
    end else if (srst_i) begin
      up_q <= '0;
      dn_q <= '1;
    end else begin
      if (wr_up_i)   up_q <= wdata_i;
      else if (step) up_q <= up_q + 1'b1;
      if (wr_dn_i)   dn_q <= wdata_i;
      else if (step) dn_q <= dn_q - 1'b1;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;

  AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (tick_i && !hold_i && !srst_i && !wr_up_i && !wr_dn_i) |=>
      (up_q == $past(up_q) + 1'b1) && (dn_q == $past(dn_q) - 1'b1)); // R2
  AST_HOLD_STILL: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (hold_i && !srst_i && !wr_up_i && !wr_dn_i) |=> $stable(up_q) && $stable(dn_q)); // R2
  AST_SRST_PAIR: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    srst_i |=> (up_q == '0) && (dn_q == '1)); // R7
endmodule

// File: rtl/sec_cmp_unit.sv
module sec_cmp_unit #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          por_ni,
  input  logic          rst_ni,
  input  logic [DW-1:0] up_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          clr_i,
  output logic [DW-1:0] cmp_o,
  output logic          hit_o,
  output logic          sts_o
);
  logic [DW-1:0] cmp_q;
  logic          sts_q;

  assign hit_o = (up_i == cmp_q);

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      cmp_q <= '1;
      sts_q <= 1'b0;
    end else begin
      if (wr_i) cmp_q <= wdata_i;
      sts_q <= (sts_q && !clr_i) || hit_o;
    end
  end

  assign cmp_o = cmp_q;
  assign sts_o = sts_q;

  AST_HIT_LATCH: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (up_i == cmp_q) |=> sts_q); // R3
  AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (sts_q && !clr_i) |=> sts_q); // R3
endmodule

// File: rtl/sec_scratch_ram.sv
module sec_scratch_ram #(
  parameter int unsigned WORDS = 32,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[idx_i] <= wdata_i;
  end

  assign rdata_o = mem[idx_i];
endmodule

// File: rtl/sec_match_timer.sv
module sec_match_timer
  import sec_match_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned RAM_WORDS = 32,
  parameter logic [31:0] KEY_VALUE = 32'hB5C13F27
) (
  input  logic          clk_i,
  input  logic          por_ni,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          irq_o,
  output logic          wake_o
);
  localparam int unsigned IW = $clog2(RAM_WORDS);

  logic [AW-1:0] word_a, ram_off;
  logic sel_up, sel_dn, sel_ctrl, sel_sts, sel_key, sel_ram;
  logic [NUM_CMP-1:0] sel_cmp, hit, sts;
  logic [DW-1:0] cmp_val [NUM_CMP];
  logic [DW-1:0] up_val, dn_val, key_q, ram_rd;
  logic [7:0] ctrl_q;
  logic wake_sts_q, key_ok, wr_ok, srst, wake_hit;

  assign word_a   = {addr_i[AW-1:2], 2'b00};
  assign sel_up   = word_a == AW'(OFS_UP);
  assign sel_dn   = word_a == AW'(OFS_DN);
  assign sel_ctrl = word_a == AW'(OFS_CTRL);
  assign sel_sts  = word_a == AW'(OFS_STS);
  assign sel_key  = word_a == AW'(OFS_KEY);
  assign ram_off  = word_a - AW'(OFS_RAM);
  assign sel_ram  = (word_a >= AW'(OFS_RAM)) && (int'(ram_off[AW-1:2]) < int'(RAM_WORDS));

  assign key_ok = key_q == KEY_VALUE;
  assign wr_ok  = wr_en_i && rst_ni;
  assign srst   = ctrl_q[CB_SRST] || (!rst_ni && !key_ok);

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      ctrl_q <= '0;
    end else if (!rst_ni) begin
      if (!key_ok) ctrl_q <= '0;
    end else if (wr_en_i && sel_ctrl) begin
      ctrl_q <= wdata_i[7:0] & CTRL_MASK;
    end
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)                key_q <= '0;
    else if (wr_ok && sel_key)  key_q <= wdata_i;
  end

  sec_counter_pair #(.DW(DW)) u_cnt (
    .clk_i   (clk_i),
    .por_ni  (por_ni),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .hold_i  (ctrl_q[CB_HOLD]),
    .srst_i  (srst),
    .wr_up_i (wr_ok && sel_up),
    .wr_dn_i (wr_ok && sel_dn),
    .wdata_i (wdata_i),
    .up_o    (up_val),
    .dn_o    (dn_val)
  );

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    assign sel_cmp[k] = word_a == AW'(OFS_CMP0 + 4 * k);
    sec_cmp_unit #(.DW(DW)) u_cmp (
      .clk_i   (clk_i),
      .por_ni  (por_ni),
      .rst_ni  (rst_ni),
      .up_i    (up_val),
      .wr_i    (wr_ok && sel_cmp[k]),
      .wdata_i (wdata_i),
      .clr_i   (wr_ok && sel_sts && wdata_i[k]),
      .cmp_o   (cmp_val[k]),
      .hit_o   (hit[k]),
      .sts_o   (sts[k])
    );
  end

  // wake event: a hit on any compare routed to the wake path
  assign wake_hit = |(hit & ctrl_q[CB_WK0 +: NUM_CMP]);

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) wake_sts_q <= 1'b0;
    else         wake_sts_q <= (wake_sts_q && !(wr_ok && sel_sts && wdata_i[SB_WAKE])) || wake_hit;
  end

  sec_scratch_ram #(.WORDS(RAM_WORDS), .DW(DW)) u_ram (
    .clk_i   (clk_i),
    .we_i    (wr_ok && sel_ram),
    .idx_i   (ram_off[2 +: IW]),
    .wdata_i (wdata_i),
    .rdata_o (ram_rd)
  );

  assign irq_o  = |(sts & ctrl_q[CB_EN0 +: NUM_CMP]);
  assign wake_o = ctrl_q[CB_FORCE] || |(sts & ctrl_q[CB_WK0 +: NUM_CMP]);

  always_comb begin
    rdata_o = '0;
    if (sel_up)       rdata_o = up_val;
    else if (sel_dn)  rdata_o = dn_val;
    else if (sel_ctrl) rdata_o = {24'b0, ctrl_q};
    else if (sel_sts) rdata_o = {29'b0, wake_sts_q, sts};
    else if (sel_key) rdata_o = key_q;
    else if (sel_ram) rdata_o = ram_rd;
    else begin
      for (int k = 0; k < NUM_CMP; k++)
        if (sel_cmp[k]) rdata_o = cmp_val[k];
    end
  end

  AST_FORCE_WAKE: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    ctrl_q[CB_FORCE] |-> wake_o); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    !(sel_up || sel_dn || sel_ctrl || sel_sts || sel_key || sel_ram || |sel_cmp) |-> rdata_o == '0); // R1
  AST_WAKE_LATCH: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    wake_hit |=> wake_sts_q); // R5
  AST_NOKEY_CLEAR: assert property (@(posedge clk_i) disable iff (!por_ni)
    (!rst_ni && !key_ok) |=> (ctrl_q == '0) && (up_val == '0)); // R9
endmodule

// File: tb/sec_match_timer_bench.sv
`timescale 1ns/1ps
module sec_match_timer_bench;
  localparam int unsigned AW = 8;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, wake;

  always #2.5 clk = ~clk;

  sec_match_timer #(.AW(AW)) u_sec_match_timer (
    .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n), .tick_i(tick),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  typedef struct {
    int          kind;   // 0 rdata, 1 irq, 2 wake
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int vectors = 0, miscompares = 0;
  bit done = 0;

  // monitor: samples mid-low phase, well away from the rising edge
  always @(negedge clk) begin
    #1.5;
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      act = (it.kind == 0) ? rdata : (it.kind == 1) ? {31'b0, irq} : {31'b0, wake};
      vectors++;
      if (act !== it.exp) begin
        miscompares++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic exp_rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    addr = a;
    it.kind = 0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic exp_pin(input int kind, input logic e, input string tag);
    item_t it;
    it.kind = kind; it.exp = {31'b0, e}; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic sys_reset();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);

    // R10 power-on state
    exp_rd(8'h10, 32'h0, "R10 ctrl");
    exp_rd(8'h00, 32'h0, "R10 up");
    exp_rd(8'h04, 32'hFFFF_FFFF, "R10 down");
    exp_rd(8'h08, 32'hFFFF_FFFF, "R10 cmp0");
    exp_rd(8'h0C, 32'hFFFF_FFFF, "R10 cmp1");
    exp_rd(8'h14, 32'h0, "R10 status");
    exp_rd(8'h18, 32'h0, "R10 key");
    exp_pin(1, 1'b0, "R10 irq");
    exp_pin(2, 1'b0, "R10 wake");

    // R2 counting and hold
    ticks(3);
    exp_rd(8'h00, 32'd3, "R2 up after 3 ticks");
    exp_rd(8'h04, 32'hFFFF_FFFC, "R2 down after 3 ticks");
    wr(8'h10, 32'h40);
    ticks(2);
    exp_rd(8'h00, 32'd3, "R2 hold up");
    exp_rd(8'h04, 32'hFFFF_FFFC, "R2 hold down");
    wr(8'h00, 32'd100);
    wr(8'h04, 32'hFFFF_FF9B);
    wr(8'h10, 32'h0);
    exp_rd(8'h00, 32'd100, "R2 loaded up");
    exp_rd(8'h04, 32'hFFFF_FF9B, "R2 loaded down");

    // R3 / R4 compare 0
    wr(8'h08, 32'd102);
    wr(8'h10, 32'h01);
    ticks(2);
    idle(1);
    exp_rd(8'h14, 32'h1, "R3 status0 latched");
    exp_pin(1, 1'b1, "R4 irq with enable");
    wr(8'h14, 32'h0);
    exp_rd(8'h14, 32'h1, "R3 zero write keeps status");
    wr(8'h10, 32'h0);
    exp_pin(1, 1'b0, "R4 irq masked");
    exp_rd(8'h14, 32'h1, "R4 status held while masked");
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h14, 32'h1);
    exp_rd(8'h14, 32'h0, "R3 status cleared after park");

    // R5 wake routing on compare 1
    wr(8'h0C, 32'd103);
    wr(8'h10, 32'h08);
    ticks(1);
    idle(1);
    exp_rd(8'h14, 32'h6, "R5 status1 and wake event");
    exp_pin(1, 1'b0, "R5 irq off with enable1 clear");
    exp_pin(2, 1'b1, "R5 wake routed");
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h14, 32'h6);
    exp_rd(8'h14, 32'h0, "R5 status cleared");
    exp_pin(2, 1'b0, "R5 wake low");

    // R6 force
    wr(8'h10, 32'h80);
    exp_pin(2, 1'b1, "R6 force wake");
    exp_pin(1, 1'b0, "R6 irq unaffected");
    wr(8'h10, 32'h0);
    exp_pin(2, 1'b0, "R6 release");

    // R8 scratch RAM, then R7 software reset
    wr(8'h80, 32'hDEAD_BEEF);
    wr(8'hFC, 32'h1234_5678);
    exp_rd(8'h80, 32'hDEAD_BEEF, "R8 ram word 0");
    exp_rd(8'hFC, 32'h1234_5678, "R8 ram word 31");
    wr(8'h10, 32'h10);
    idle(1);
    exp_rd(8'h00, 32'h0, "R7 up held at 0");
    exp_rd(8'h04, 32'hFFFF_FFFF, "R7 down held");
    ticks(2);
    exp_rd(8'h00, 32'h0, "R7 ticks ignored");
    exp_rd(8'h80, 32'hDEAD_BEEF, "R8 ram kept through sw reset");
    exp_rd(8'hFC, 32'h1234_5678, "R8 ram end kept through sw reset");
    wr(8'h10, 32'h0);
    ticks(1);
    exp_rd(8'h00, 32'd1, "R7 counting resumes");
    exp_rd(8'h04, 32'hFFFF_FFFE, "R7 down resumes");

    // R1 unmapped and reserved bit
    wr(8'h1C, 32'hFFFF_FFFF);
    exp_rd(8'h1C, 32'h0, "R1 unmapped 0x1C");
    wr(8'h20, 32'hA5A5_A5A5);
    exp_rd(8'h20, 32'h0, "R1 unmapped 0x20");
    wr(8'h10, 32'h20);
    exp_rd(8'h10, 32'h0, "R1 ctrl bit5 reads 0");
    exp_rd(8'h00, 32'd1, "R1 unmapped writes left up count");

    // R9 key retention
    wr(8'h10, 32'h01);
    sys_reset();
    exp_rd(8'h10, 32'h0, "R9 no key clears ctrl");
    exp_rd(8'h00, 32'h0, "R9 no key clears up");
    exp_rd(8'h04, 32'hFFFF_FFFF, "R9 no key resets down");
    wr(8'h18, 32'hB5C1_3F27);
    wr(8'h10, 32'h81);
    ticks(4);
    sys_reset();
    exp_rd(8'h10, 32'h81, "R9 key keeps ctrl");
    exp_rd(8'h00, 32'd4, "R9 key keeps up");
    exp_rd(8'h04, 32'hFFFF_FFFB, "R9 key keeps down");
    exp_rd(8'h18, 32'hB5C1_3F27, "R9 key readback");
    exp_pin(2, 1'b1, "R9 retained force wake");

    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule